// File: doc/BRIEF.md
# Accumulator Processor with Hardwired Sequencer

A small accumulator machine that executes programs out of its own word memory. A 4-bit step counter drives a fixed sequence for every instruction. Steps 0 to 2 fetch and decode the word. Step 3 either resolves an indirect address or carries out a register operation. Steps 4 to 6 carry out the memory-reference operations. All register traffic goes over one internal bus, and a 3-bit code chooses its source.

The block is used by holding reset and writing a program through the preload port. Reset is then released, and execution starts at address 0. Execution continues until a halt operation clears the run flag. A combinational peek port reads any memory word at any time, so results left in memory can be inspected after the halt.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, and in the cycle after it rises, run_o=1 and pc_o, acc_o and ecarry_o are 0. The step counter is 0, so the first fetch is from address 0.
- R2: An instruction word has the addressing flag in bit 15, the opcode in bits 14..12 and the address or operation field in bits 11..0. Steps 0 to 2 fetch the word at the PC, advance the PC by one, and latch the address field and the flag.
- R3: When bit 15 is 1 and the opcode is 0 to 6, step 3 replaces the address with the low 12 bits of the memory word at that address.
- R4: Opcode 0 ANDs the operand into AC. Opcode 1 adds the operand to AC and puts the carry out in E. Opcode 2 loads the operand into AC. Each of these takes 6 cycles, and opcodes 0 and 2 leave E unchanged.
- R5: Opcode 3 writes AC to the effective address in 5 cycles. Opcode 4 jumps to the effective address in 5 cycles.
- R6: Opcode 5 stores the address of the next instruction at the effective address and continues at the effective address plus one. It takes 6 cycles.
- R7: Opcode 6 increments the memory word at the effective address and skips the next instruction when the new value is 0. It takes 7 cycles.
- R8: Opcode 7 with bit 15 clear is a register operation of 4 cycles. The operation field selects: bit 11 clears AC, bit 10 clears E, bit 9 complements AC, bit 8 complements E and bit 5 increments AC.
- R9: Operation bit 7 rotates {AC,E} right: bit 0 of AC goes into E, and E goes into bit 15. Operation bit 6 rotates left: bit 15 goes into E, and E goes into bit 0.
- R10: The skip bits advance the PC by one more. Bit 4 skips if AC bit 15 is 0, bit 3 if AC bit 15 is 1, bit 2 if AC is 0, and bit 1 if E is 0.
- R11: Operation bit 0 clears run_o, after which PC, AC and E hold until reset. The preload port writes memory at the next edge, and the peek port reads combinationally.
- R12: Opcode 7 with bit 15 set changes no register except the PC advance of the fetch, and takes 4 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Preload write strobe |
| load_addr | input | 12 | Preload word address |
| load_data | input | 16 | Preload word value |
| peek_addr | input | 12 | Inspection read address |
| peek_data | output | 16 | Memory word at peek_addr |
| acc_o | output | 16 | Accumulator |
| ecarry_o | output | 1 | Carry/extension flag E |
| pc_o | output | 12 | Program counter |
| run_o | output | 1 | Run flag, 0 after a halt |

## Verification
Each visible result appears at a fixed number of edges after its instruction's fetch begins. A register operation is visible after the fourth edge. Store and jump are visible after the fifth, AND, add, load and subroutine call after the sixth, and increment-and-skip after the seventh. The bench's behavioural model advances on the same rising edge as the design and is compared half a period later on every clock. Any result that lands one step early or late therefore shows up as a mismatch in that cycle. Memory results and final register values are also compared with hand-derived constants after the halt.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

   localparam int REGOP_W = 12;

   // positions inside the register-operation field
   localparam int RB_CLA = 11;
   localparam int RB_CLE = 10;
   localparam int RB_CMA = 9;
   localparam int RB_CME = 8;
   localparam int RB_CIR = 7;
   localparam int RB_CIL = 6;
   localparam int RB_INC = 5;
   localparam int RB_SPA = 4;
   localparam int RB_SNA = 3;
   localparam int RB_SZA = 2;
   localparam int RB_SZE = 1;
   localparam int RB_HLT = 0;

   localparam logic [2:0] OPC_AND = 3'd0;
   localparam logic [2:0] OPC_ADD = 3'd1;
   localparam logic [2:0] OPC_LDA = 3'd2;
   localparam logic [2:0] OPC_STA = 3'd3;
   localparam logic [2:0] OPC_BUN = 3'd4;
   localparam logic [2:0] OPC_BSA = 3'd5;
   localparam logic [2:0] OPC_ISZ = 3'd6;
   localparam logic [2:0] OPC_REG = 3'd7;

   typedef enum logic [2:0] {
      BUS_NONE = 3'd0, BUS_AR = 3'd1, BUS_PC = 3'd2, BUS_DR = 3'd3,
      BUS_AC = 3'd4, BUS_IR = 3'd5, BUS_TMP = 3'd6, BUS_MEM = 3'd7
   } bus_sel_e;

   typedef enum logic [2:0] {
      ALU_HOLD, ALU_AND, ALU_ADD, ALU_LOAD, ALU_REG
   } alu_op_e;

   typedef struct packed {
      bus_sel_e             sel;
      logic                 ld_ar;
      logic                 inc_ar;
      logic                 ld_pc;
      logic                 inc_pc;
      logic                 ld_ir;
      logic                 ld_dr;
      logic                 inc_dr;
      logic                 mem_we;
      logic                 set_i;
      logic                 sc_clr;
      logic                 halt;
      alu_op_e              alu;
      logic [REGOP_W-1:0]   rmask;
   } ctrl_s;

endpackage

// File: rtl/acc_cpu_mem.sv
module acc_cpu_mem #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12,
   parameter int MEM_AW = 10
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   input  logic [ADDR_W-1:0] paddr,
   output logic [DATA_W-1:0] pdata
);
   localparam int WORDS = 1 << MEM_AW;

   logic [DATA_W-1:0] words_q [WORDS];
   logic [MEM_AW-1:0] wi, ri, pi;

   generate
      if (MEM_AW > ADDR_W) begin : g_bad_depth
         $error("acc_cpu_mem: MEM_AW exceeds ADDR_W");
      end
      if (MEM_AW == ADDR_W) begin : g_full
         assign wi = waddr;
         assign ri = raddr;
         assign pi = paddr;
      end else begin : g_wrap
         // addresses above the populated range alias onto it
         assign wi = waddr[MEM_AW-1:0];
         assign ri = raddr[MEM_AW-1:0];
         assign pi = paddr[MEM_AW-1:0];
         logic unused_hi;
         assign unused_hi = ^{waddr[ADDR_W-1:MEM_AW], raddr[ADDR_W-1:MEM_AW],
                              paddr[ADDR_W-1:MEM_AW]};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we) words_q[wi] <= wdata;
   end

   assign rdata = words_q[ri];
   assign pdata = words_q[pi];

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  alu_op_e            op,
   input  logic [REGOP_W-1:0] rmask,
   input  logic [DATA_W-1:0]  ac,
   input  logic               e,
   input  logic [DATA_W-1:0]  dr,
   output logic [DATA_W-1:0]  ac_n,
   output logic               e_n
);
   logic [DATA_W:0] sum;
   logic            unused_skip;

   assign sum         = {1'b0, ac} + {1'b0, dr};
   assign unused_skip = ^rmask[RB_SPA:RB_HLT];

   always_comb begin
      ac_n = ac;
      e_n  = e;
      unique case (op)
         ALU_AND:  ac_n = ac & dr;
         ALU_ADD:  {e_n, ac_n} = sum;
         ALU_LOAD: ac_n = dr;
         ALU_REG: begin
            if (rmask[RB_CLA])      ac_n = '0;
            else if (rmask[RB_CMA]) ac_n = ~ac;
            else if (rmask[RB_CIR]) ac_n = {e, ac[DATA_W-1:1]};
            else if (rmask[RB_CIL]) ac_n = {ac[DATA_W-2:0], e};
            else if (rmask[RB_INC]) ac_n = ac + 1'b1;

            if (rmask[RB_CLE])      e_n = 1'b0;
            else if (rmask[RB_CME]) e_n = ~e;
            else if (rmask[RB_CIR]) e_n = ac[0];
            else if (rmask[RB_CIL]) e_n = ac[DATA_W-1];
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
   import acc_cpu_pkg::*;
#(
   parameter int SC_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [14:0]       ir_lo,
   input  logic              i_flag,
   input  logic              ac_neg,
   input  logic              ac_zero,
   input  logic              e_flag,
   input  logic              dr_zero,
   output ctrl_s             ctl,
   output logic [SC_W-1:0]   sc
);
   logic [2:0]         opc;
   logic               d7;
   logic [REGOP_W-1:0] fld;
   logic               skip;
   ctrl_s              c;

   assign opc = ir_lo[14:12];
   assign fld = ir_lo[REGOP_W-1:0];
   assign d7  = (opc == OPC_REG);

   assign skip = (fld[RB_SPA] & ~ac_neg) | (fld[RB_SNA] & ac_neg) |
                 (fld[RB_SZA] & ac_zero) | (fld[RB_SZE] & ~e_flag);

   always_comb begin
      c = '0;
      unique case (sc)
         4'd0: begin c.sel = BUS_PC;  c.ld_ar = 1'b1; end
         4'd1: begin c.sel = BUS_MEM; c.ld_ir = 1'b1; c.inc_pc = 1'b1; end
         4'd2: begin c.sel = BUS_IR;  c.ld_ar = 1'b1; c.set_i = 1'b1; end
         4'd3: begin
            if (!d7) begin
               if (i_flag) begin c.sel = BUS_MEM; c.ld_ar = 1'b1; end
            end else begin
               c.sc_clr = 1'b1;
               if (!i_flag) begin
                  c.alu    = ALU_REG;
                  c.rmask  = fld;
                  c.halt   = fld[RB_HLT];
                  c.inc_pc = skip;
               end
            end
         end
         4'd4: begin
            unique case (opc)
               OPC_STA: begin c.sel = BUS_AC; c.mem_we = 1'b1; c.sc_clr = 1'b1; end
               OPC_BUN: begin c.sel = BUS_AR; c.ld_pc = 1'b1;  c.sc_clr = 1'b1; end
               OPC_BSA: begin c.sel = BUS_PC; c.mem_we = 1'b1; c.inc_ar = 1'b1; end
               default: begin c.sel = BUS_MEM; c.ld_dr = 1'b1; end
            endcase
         end
         4'd5: begin
            unique case (opc)
               OPC_AND: begin c.alu = ALU_AND;  c.sc_clr = 1'b1; end
               OPC_ADD: begin c.alu = ALU_ADD;  c.sc_clr = 1'b1; end
               OPC_LDA: begin c.alu = ALU_LOAD; c.sc_clr = 1'b1; end
               OPC_BSA: begin c.sel = BUS_AR; c.ld_pc = 1'b1; c.sc_clr = 1'b1; end
               OPC_ISZ: c.inc_dr = 1'b1;
               default: c.sc_clr = 1'b1;
            endcase
         end
         4'd6: begin
            c.sc_clr = 1'b1;
            if (opc == OPC_ISZ) begin
               c.sel    = BUS_DR;
               c.mem_we = 1'b1;
               c.inc_pc = dr_zero;
            end
         end
         default: c.sc_clr = 1'b1;
      endcase
   end

   assign ctl = c;

   always_ff @(posedge clk) begin
      if (!rst_n)       sc <= '0;
      else if (run)     sc <= c.sc_clr ? '0 : sc + 1'b1;
   end

   AST_STORE_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
      (run && c.mem_we) |-> (sc == 4'd4 || sc == 4'd6)); // R5

   AST_OPC7_ENDS_AT_T3: assert property (@(posedge clk) disable iff (!rst_n)
      (run && sc == 4'd3 && d7) |=> (sc == '0)); // R8

   AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      sc <= 4'd6); // R2

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
   import acc_cpu_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 12,
   parameter int MEM_AW = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [DATA_W-1:0] load_data,
   input  logic [ADDR_W-1:0] peek_addr,
   output logic [DATA_W-1:0] peek_data,
   output logic [DATA_W-1:0] acc_o,
   output logic              ecarry_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic              run_o
);
   localparam int SC_W  = 4;
   localparam int PAD_W = DATA_W - ADDR_W;

   generate
      if (ADDR_W != REGOP_W) begin : g_bad_addr
         $error("acc_cpu: ADDR_W must equal the operation field width");
      end
      if (PAD_W != 4) begin : g_bad_data
         $error("acc_cpu: DATA_W must be ADDR_W plus flag and opcode");
      end
   endgenerate

   logic [ADDR_W-1:0] ar_q, pc_q;
   logic [DATA_W-1:0] dr_q, ac_q, ir_q;
   logic              e_q, i_q, s_q;
   logic [DATA_W-1:0] bus, mem_rd, mem_wd, ac_n;
   logic [ADDR_W-1:0] mem_wa;
   logic              e_n, mem_we;
   logic [SC_W-1:0]   sc;
   ctrl_s             ctl;

   acc_cpu_ctrl #(.SC_W(SC_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (s_q),
      .ir_lo   (ir_q[DATA_W-2:0]),
      .i_flag  (i_q),
      .ac_neg  (ac_q[DATA_W-1]),
      .ac_zero (ac_q == '0),
      .e_flag  (e_q),
      .dr_zero (dr_q == '0),
      .ctl     (ctl),
      .sc      (sc)
   );

   acc_cpu_alu #(.DATA_W(DATA_W)) u_alu (
      .op    (ctl.alu),
      .rmask (ctl.rmask),
      .ac    (ac_q),
      .e     (e_q),
      .dr    (dr_q),
      .ac_n  (ac_n),
      .e_n   (e_n)
   );

   // preload has priority over the processor's own store
   assign mem_we = load_en | (s_q & ctl.mem_we);
   assign mem_wa = load_en ? load_addr : ar_q;
   assign mem_wd = load_en ? load_data : bus;

   acc_cpu_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_mem (
      .clk   (clk),
      .we    (mem_we),
      .waddr (mem_wa),
      .wdata (mem_wd),
      .raddr (ar_q),
      .rdata (mem_rd),
      .paddr (peek_addr),
      .pdata (peek_data)
   );

   always_comb begin
      unique case (ctl.sel)
         BUS_AR:  bus = {{PAD_W{1'b0}}, ar_q};
         BUS_PC:  bus = {{PAD_W{1'b0}}, pc_q};
         BUS_DR:  bus = dr_q;
         BUS_AC:  bus = ac_q;
         BUS_IR:  bus = ir_q;
         BUS_MEM: bus = mem_rd;
         default: bus = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ar_q <= '0; pc_q <= '0; dr_q <= '0; ac_q <= '0; ir_q <= '0;
         e_q  <= 1'b0; i_q <= 1'b0; s_q <= 1'b1;
      end else if (s_q) begin
         if (ctl.ld_ar)       ar_q <= bus[ADDR_W-1:0];
         else if (ctl.inc_ar) ar_q <= ar_q + 1'b1;
         if (ctl.ld_pc)       pc_q <= bus[ADDR_W-1:0];
         else if (ctl.inc_pc) pc_q <= pc_q + 1'b1;
         if (ctl.ld_ir)       ir_q <= bus;
         if (ctl.ld_dr)       dr_q <= bus;
         else if (ctl.inc_dr) dr_q <= dr_q + 1'b1;
         if (ctl.set_i)       i_q  <= ir_q[DATA_W-1];
         ac_q <= ac_n;
         e_q  <= e_n;
         if (ctl.halt)        s_q  <= 1'b0;
      end
   end

   assign acc_o    = ac_q;
   assign ecarry_o = e_q;
   assign pc_o     = pc_q;
   assign run_o    = s_q;

   AST_FETCH_ADVANCES_PC: assert property (@(posedge clk) disable iff (!rst_n)
      (s_q && sc == 4'd1) |=> (pc_q == $past(pc_q) + 1'b1)); // R2

   AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
      !s_q |=> ($stable(pc_q) && $stable(ac_q) && $stable(e_q))); // R11

   AST_ADD_CARRY_TO_E: assert property (@(posedge clk) disable iff (!rst_n)
      (s_q && ctl.alu == ALU_ADD) |=>
         ({e_q, ac_q} == $past({1'b0, ac_q}) + $past({1'b0, dr_q}))); // R4

   AST_ROTATE_KEEPS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (s_q && ctl.alu == ALU_REG && (ctl.rmask[RB_CIR] ^ ctl.rmask[RB_CIL]) &&
       ctl.rmask[RB_CLA:RB_CME] == '0 && !ctl.rmask[RB_INC]) |=>
         ($countones({ac_q, e_q}) == $past($countones({ac_q, e_q})))); // R9

endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
   localparam int DW = 16;
   localparam int AW = 12;
   localparam int MW = 1024;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          load_en = 1'b0;
   logic [AW-1:0] load_addr = '0;
   logic [DW-1:0] load_data = '0;
   logic [AW-1:0] peek_addr = '0;
   logic [DW-1:0] peek_data, acc_o;
   logic          ecarry_o, run_o;
   logic [AW-1:0] pc_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   acc_cpu u_acc_cpu (
      .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
      .load_data(load_data), .peek_addr(peek_addr), .peek_data(peek_data),
      .acc_o(acc_o), .ecarry_o(ecarry_o), .pc_o(pc_o), .run_o(run_o)
   );

   // ---------------- behavioural reference ----------------
   logic [DW-1:0] m_mem [MW];
   logic [AW-1:0] m_ar, m_pc;
   logic [DW-1:0] m_dr, m_ac, m_ir;
   logic          m_e, m_i, m_s;
   int            m_sc;

   task automatic model_step();
      int         nsc = m_sc + 1;
      logic [2:0] op  = m_ir[14:12];
      logic       skip;
      logic [DW:0] sum;
      logic       t;
      case (m_sc)
         0: m_ar = m_pc;
         1: begin m_ir = m_mem[int'(m_ar) % MW]; m_pc = m_pc + 1; end
         2: begin m_ar = m_ir[11:0]; m_i = m_ir[15]; end
         3: begin
            if (op != 3'd7) begin
               if (m_i) m_ar = m_mem[int'(m_ar) % MW][11:0];
            end else begin
               nsc = 0;
               if (!m_i) begin
                  skip = (m_ir[4] && !m_ac[15]) || (m_ir[3] && m_ac[15]) ||
                         (m_ir[2] && m_ac == 0) || (m_ir[1] && !m_e);
                  if (m_ir[11]) m_ac = 0;
                  if (m_ir[10]) m_e = 0;
                  if (m_ir[9])  m_ac = ~m_ac;
                  if (m_ir[8])  m_e = ~m_e;
                  if (m_ir[7]) begin t = m_ac[0]; m_ac = {m_e, m_ac[15:1]}; m_e = t; end
                  if (m_ir[6]) begin t = m_ac[15]; m_ac = {m_ac[14:0], m_e}; m_e = t; end
                  if (m_ir[5])  m_ac = m_ac + 1;
                  if (m_ir[0])  m_s = 0;
                  if (skip)     m_pc = m_pc + 1;
               end
            end
         end
         4: case (op)
               3'd3: begin m_mem[int'(m_ar) % MW] = m_ac; nsc = 0; end
               3'd4: begin m_pc = m_ar; nsc = 0; end
               3'd5: begin m_mem[int'(m_ar) % MW] = {4'h0, m_pc}; m_ar = m_ar + 1; end
               default: m_dr = m_mem[int'(m_ar) % MW];
            endcase
         5: case (op)
               3'd0: begin m_ac = m_ac & m_dr; nsc = 0; end
               3'd1: begin sum = {1'b0, m_ac} + {1'b0, m_dr}; m_ac = sum[15:0];
                           m_e = sum[16]; nsc = 0; end
               3'd2: begin m_ac = m_dr; nsc = 0; end
               3'd5: begin m_pc = m_ar; nsc = 0; end
               default: m_dr = m_dr + 1;
            endcase
         default: begin
            m_mem[int'(m_ar) % MW] = m_dr;
            if (m_dr == 0) m_pc = m_pc + 1;
            nsc = 0;
         end
      endcase
      m_sc = nsc;
   endtask

   always @(posedge clk) begin
      if (load_en) m_mem[int'(load_addr) % MW] = load_data;
      if (!rst_n) begin
         m_ar = 0; m_pc = 0; m_dr = 0; m_ac = 0; m_ir = 0;
         m_e = 0; m_i = 0; m_s = 1; m_sc = 0;
      end else if (m_s) begin
         model_step();
      end
   end

   // ---------------- checking ----------------
   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // every-cycle comparison with the reference, half a period after the edge
   always @(negedge clk) begin
      if (rst_n) begin
         check(pc_o === m_pc, "R2", "pc trace", int'(pc_o), int'(m_pc));
         check(acc_o === m_ac, "R4", "ac trace", int'(acc_o), int'(m_ac));
         check(ecarry_o === m_e, "R9", "e trace", int'(ecarry_o), int'(m_e));
         check(run_o === m_s, "R11", "run trace", int'(run_o), int'(m_s));
      end
   end

   task automatic put(input int a, input int d);
      @(negedge clk);
      load_en   = 1'b1;
      load_addr = AW'(a);
      load_data = DW'(d);
   endtask

   task automatic begin_load();
      @(negedge clk);
      rst_n = 1'b0;
   endtask

   task automatic launch();
      @(negedge clk);
      load_en = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check(run_o === 1'b1 && pc_o === '0 && acc_o === '0 && ecarry_o === 1'b0,
            "R1", "reset state", int'({run_o, pc_o}), 'h1000);
   endtask

   task automatic wait_halt(input string req);
      int cnt = 0;
      logic [AW-1:0] pc_hold;
      @(negedge clk);
      while (run_o === 1'b1 && cnt < 3000) begin
         @(negedge clk);
         cnt++;
      end
      check(run_o === 1'b0, req, "halt reached", int'(run_o), 0);
      pc_hold = pc_o;
      repeat (4) @(negedge clk);
      check(pc_o === pc_hold, "R11", "pc held after halt", int'(pc_o), int'(pc_hold));
   endtask

   task automatic peek(input int a, input int exp, input string req);
      @(negedge clk);
      peek_addr = AW'(a);
      #1;
      check(peek_data === DW'(exp), req, $sformatf("mem[%0h]", a),
            int'(peek_data), exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      for (int a = 0; a < 128; a++) put(a, 0);

      // program A: direct load, indirect add with carry, AND, store, opcode 7 with flag
      begin_load();
      put('h00, 'h2020); put('h01, 'h9021); put('h02, 'h0023); put('h03, 'h3024);
      put('h04, 'hF800); put('h05, 'h7001);
      put('h20, 'h7FFF); put('h21, 'h0022); put('h22, 'h8003); put('h23, 'h00F3);
      put('h24, 'hFFFF);
      launch();
      wait_halt("R11");
      check(acc_o === 16'h0002, "R3", "indirect add then and", int'(acc_o), 2);
      check(ecarry_o === 1'b1, "R4", "carry into e", int'(ecarry_o), 1);
      check(pc_o === 12'h006, "R12", "pc after no-op and halt", int'(pc_o), 6);
      peek('h24, 'h0002, "R5");

      // program B: subroutine call and indirect return
      begin_load();
      put('h00, 'h2030); put('h01, 'h5010); put('h02, 'h3031); put('h03, 'h7001);
      put('h10, 'h0000); put('h11, 'h7020); put('h12, 'h7020); put('h13, 'hC010);
      put('h30, 'h0005); put('h31, 'hFFFF);
      launch();
      wait_halt("R11");
      peek('h10, 'h0002, "R6");
      check(pc_o === 12'h004, "R6", "pc after return and halt", int'(pc_o), 4);
      check(acc_o === 16'h0007, "R8", "two increments", int'(acc_o), 7);
      peek('h31, 'h0007, "R5");

      // program C: increment-and-skip loop
      begin_load();
      put('h00, 'h6040); put('h01, 'h4000); put('h02, 'h7001);
      put('h40, 'hFFFD);
      launch();
      wait_halt("R11");
      peek('h40, 'h0000, "R7");
      check(pc_o === 12'h003, "R7", "skip out of loop", int'(pc_o), 3);

      // program D: rotations through E, complements, skips
      begin_load();
      put(0, 'h2050);  put(1, 'h7400);  put(2, 'h7040);  put(3, 'h7080);
      put(4, 'h7080);  put(5, 'h3052);  put(6, 'h7002);  put(7, 'h7100);
      put(8, 'h7002);  put(9, 'h7001);  put(10, 'h7008); put(11, 'h7200);
      put(12, 'h7010); put(13, 'h7008); put(14, 'h7001); put(15, 'h7800);
      put(16, 'h7004); put(17, 'h7001); put(18, 'h3051); put(19, 'h7001);
      put('h50, 'h8001); put('h51, 'hFFFF); put('h52, 'hFFFF);
      launch();
      wait_halt("R11");
      peek('h52, 'h4000, "R9");
      check(ecarry_o === 1'b0, "R9", "e after complement", int'(ecarry_o), 0);
      check(acc_o === 16'h0000, "R8", "clear ac", int'(acc_o), 0);
      check(pc_o === 12'h014, "R10", "skips taken", int'(pc_o), 'h14);
      peek('h51, 'h0000, "R10");

      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R11 watchdog actual=%0h expected=%0h", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule